// File: doc/BRIEF.md
# Power-Pulsing Cycle Controller

This block sets the timing of a repeating power-on window for a group of front-end chips and gates external triggers against it. A free-running phase counter defines a period and a shorter on-window at its start. Three power-enable lines (analog, threshold DAC and digital acquisition) follow that window. A mask input can instead hold any of them permanently high. An acquisition-enable goes high only after a wake-up interval has elapsed inside the window. Triggers that arrive earlier would produce records with no data, so they are vetoed.

A timestamp-counter reset pulse is issued at the first cycle of every window, before acquisition is enabled. Because of this, the first trigger of a cycle carries the same timestamp offset as later ones. A trigger passes only when the in-spill qualifier is high, acquisition is valid and no readout is outstanding. A passed trigger marks a readout as pending, and it stays pending until the readout-done input arrives. Two saturating counters record passed and vetoed triggers. All timing is given in clock cycles by parameters. The defaults are a 10 ms period, a 2 ms window and a 100 µs wake-up veto at a 40 MHz clock. A 1-in-200 window setting works the same way.

Top module: `pwrpulse_ctrl`

## Requirements
- R1: The on-window starts in the first cycle after reset release and then every PERIOD_CYC cycles, and it lasts ON_CYC cycles.
- R2: pulseMask bit 0 controls the analog line, bit 1 the DAC line and bit 2 the digital line. A bit at 1 makes its line follow the window, and a bit at 0 holds its line high.
- R3: With all mask bits at 1, every power line and acqEnable is low outside the window.
- R4: acqEnable is high for window phases from the effective wake length up to ON_CYC-1. The effective wake length is the largest of WAKE_CYC, ANA_WAKE_CYC (only if mask bit 0 is 1) and DAC_WAKE_CYC (only if mask bit 1 is 1).
- R5: busy is high whenever acqEnable is low or a readout is pending.
- R6: trigOut equals trigIn AND inSpill AND acqEnable AND NOT pending, in the same cycle. A passed trigger makes a readout pending from the next cycle, and readoutDone clears it.
- R7: tsReset is a one-cycle pulse at window phase 0, and acqEnable is never high in the same cycle.
- R8: passCount increments for each passed trigger, and vetoCount increments for each cycle in which trigIn is high and the trigger does not pass.
- R9: Both counters hold at 2^CNT_W-1 and never wrap.
- R10: During reset the phase is 0, nothing is pending and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseMask | input | 3 | Per-line pulse select: [0] analog, [1] DAC, [2] digital |
| inSpill | input | 1 | Beam spill qualifier |
| trigIn | input | 1 | External trigger, one event per high cycle |
| readoutDone | input | 1 | Ends a pending readout |
| pwrAnalog | output | 1 | Analog power enable |
| pwrDac | output | 1 | Threshold DAC power enable |
| pwrDigital | output | 1 | Digital acquisition power enable |
| acqEnable | output | 1 | Acquisition valid |
| tsReset | output | 1 | Timestamp counter reset pulse |
| trigOut | output | 1 | Qualified trigger |
| busy | output | 1 | Not ready for a trigger |
| passCount | output | CNT_W | Saturating count of passed triggers |
| vetoCount | output | CNT_W | Saturating count of vetoed triggers |

## Verification
The assertions check several relations on every cycle. Acquisition is always backed by all three power lines, and tsReset never coincides with acqEnable. busy covers every cycle without valid acquisition and follows each passed trigger. A passed trigger never coincides with busy, the phase wraps at the period end, and the counters step by one and stop at full scale. Other behaviour needs the bench's scenarios with a cycle-exact reference model. These cover the wake length chosen by each mask combination, always-on lines, triggers dropped out of spill, and readout handshakes across window ends. They also drive both counters into saturation.

// File: rtl/pwrpulse_pkg.sv
package pwrpulse_pkg;

  localparam int NUM_LINES = 3;
  localparam int LINE_ANA  = 0;
  localparam int LINE_DAC  = 1;
  localparam int LINE_DIG  = 2;

  typedef struct packed {
    logic winOn;     // inside the power-on window
    logic acqValid;  // window reached past the wake-up interval
    logic tsReset;   // first cycle of the window
  } pp_strobe_t;

endpackage

// File: rtl/pwrpulse_satcnt.sv
module pwrpulse_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (inc && (count != MAX_VAL)) begin
      count <= count + 1'b1;
    end
  end

  // R9: a full counter stays full
  a_r9_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    (count == MAX_VAL) |=> (count == MAX_VAL));

  // R8: a counted event moves the count by exactly one
  a_r8_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (inc && (count != MAX_VAL)) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/pwrpulse_timer.sv
module pwrpulse_timer
  import pwrpulse_pkg::*;
#(
  parameter int PERIOD_CYC   = 400000,
  parameter int ON_CYC       = 80000,
  parameter int WAKE_CYC     = 4000,
  parameter int ANA_WAKE_CYC = 320,
  parameter int DAC_WAKE_CYC = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pulseMask,
  output logic [NUM_LINES-1:0] pwrLines,
  output pp_strobe_t           strobe
);

  localparam int PH_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PH_W-1:0] LAST_PH  = PH_W'(PERIOD_CYC - 1);
  localparam logic [PH_W-1:0] ON_LEN   = PH_W'(ON_CYC);
  localparam logic [PH_W-1:0] BASE_WK  = PH_W'(WAKE_CYC);
  localparam logic [PH_W-1:0] ANA_WK   = PH_W'(ANA_WAKE_CYC);
  localparam logic [PH_W-1:0] DAC_WK   = PH_W'(DAC_WAKE_CYC);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] wakeLen;
  logic            inWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (phase == LAST_PH) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // Only stages that are actually pulsed need time to settle.
  always_comb begin
    wakeLen = BASE_WK;
    if (pulseMask[LINE_ANA] && (ANA_WK > wakeLen)) wakeLen = ANA_WK;
    if (pulseMask[LINE_DAC] && (DAC_WK > wakeLen)) wakeLen = DAC_WK;
  end

  assign inWin = (phase < ON_LEN);

  always_comb begin
    strobe.winOn    = inWin;
    strobe.acqValid = inWin && (phase >= wakeLen);
    strobe.tsReset  = (phase == '0);
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    assign pwrLines[g] = pulseMask[g] ? inWin : 1'b1;
  end

  // R1: the phase wraps to the window start after the last period cycle
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (phase == LAST_PH) |=> (phase == '0));

  // R4: acquisition only while every line is powered
  a_r4_acq_powered: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acqValid |-> (&pwrLines));

endmodule

// File: rtl/pwrpulse_trig.sv
module pwrpulse_trig
  import pwrpulse_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pp_strobe_t       strobe,
  input  logic             inSpill,
  input  logic             trigIn,
  input  logic             readoutDone,
  output logic             trigOut,
  output logic             busy,
  output logic [CNT_W-1:0] passCount,
  output logic [CNT_W-1:0] vetoCount
);

  logic pending;
  logic passHit;
  logic vetoHit;

  assign passHit = trigIn && inSpill && strobe.acqValid && !pending;
  assign vetoHit = trigIn && !passHit;
  assign trigOut = passHit;
  assign busy    = !strobe.acqValid || pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (pending && readoutDone) begin
      pending <= 1'b0;
    end else if (passHit) begin
      pending <= 1'b1;
    end
  end

  pwrpulse_satcnt #(.CNT_W(CNT_W)) uPassCnt (
    .clk   (clk),
    .rstN  (rstN),
    .inc   (passHit),
    .count (passCount)
  );

  pwrpulse_satcnt #(.CNT_W(CNT_W)) uVetoCnt (
    .clk   (clk),
    .rstN  (rstN),
    .inc   (vetoHit),
    .count (vetoCount)
  );

  // R6: a passed trigger leaves the block busy in the next cycle
  a_r6_pass_then_busy: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> busy);

  // R6: nothing passes while busy
  a_r6_no_pass_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !trigOut);

  // R5: outside valid acquisition the block reports busy
  a_r5_busy_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.acqValid |-> busy);

  // R4: valid acquisition lies inside the window
  a_r4_in_window: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acqValid |-> strobe.winOn);

  // R7: the timestamp reset never overlaps valid acquisition
  a_r7_ts_first: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tsReset |-> !strobe.acqValid);

endmodule

// File: rtl/pwrpulse_ctrl.sv
module pwrpulse_ctrl
  import pwrpulse_pkg::*;
#(
  parameter int PERIOD_CYC   = 400000,
  parameter int ON_CYC       = 80000,
  parameter int WAKE_CYC     = 4000,
  parameter int ANA_WAKE_CYC = 320,
  parameter int DAC_WAKE_CYC = 1000,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       pulseMask,
  input  logic             inSpill,
  input  logic             trigIn,
  input  logic             readoutDone,
  output logic             pwrAnalog,
  output logic             pwrDac,
  output logic             pwrDigital,
  output logic             acqEnable,
  output logic             tsReset,
  output logic             trigOut,
  output logic             busy,
  output logic [CNT_W-1:0] passCount,
  output logic [CNT_W-1:0] vetoCount
);

  pp_strobe_t           strobe;
  logic [NUM_LINES-1:0] pwrLines;

  pwrpulse_timer #(
    .PERIOD_CYC   (PERIOD_CYC),
    .ON_CYC       (ON_CYC),
    .WAKE_CYC     (WAKE_CYC),
    .ANA_WAKE_CYC (ANA_WAKE_CYC),
    .DAC_WAKE_CYC (DAC_WAKE_CYC)
  ) uTimer (
    .clk       (clk),
    .rstN      (rstN),
    .pulseMask (pulseMask),
    .pwrLines  (pwrLines),
    .strobe    (strobe)
  );

  pwrpulse_trig #(.CNT_W(CNT_W)) uTrig (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inSpill     (inSpill),
    .trigIn      (trigIn),
    .readoutDone (readoutDone),
    .trigOut     (trigOut),
    .busy        (busy),
    .passCount   (passCount),
    .vetoCount   (vetoCount)
  );

  assign pwrAnalog  = pwrLines[LINE_ANA];
  assign pwrDac     = pwrLines[LINE_DAC];
  assign pwrDigital = pwrLines[LINE_DIG];
  assign acqEnable  = strobe.acqValid;
  assign tsReset    = strobe.tsReset;

endmodule

// File: tb/tb_pwrpulse_ctrl.sv
module tb_pwrpulse_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD = 60;
  localparam int ON     = 20;
  localparam int WAKE   = 5;
  localparam int ANA    = 3;
  localparam int DAC    = 8;
  localparam int CW     = 4;
  localparam int CMAX   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic [2:0]    pulseMask;
  logic          inSpill, trigIn, readoutDone;
  logic          pwrAnalog, pwrDac, pwrDigital, acqEnable, tsReset, trigOut, busy;
  logic [CW-1:0] passCount, vetoCount;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit modelOn = 1'b0;

  // reference model state
  int  mPhase = 0;
  bit  mPending = 1'b0;
  int  mPass = 0;
  int  mVeto = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrpulse_ctrl #(
    .PERIOD_CYC(PERIOD), .ON_CYC(ON), .WAKE_CYC(WAKE),
    .ANA_WAKE_CYC(ANA), .DAC_WAKE_CYC(DAC), .CNT_W(CW)
  ) dut (
    .clk(clk), .rstN(rstN), .pulseMask(pulseMask), .inSpill(inSpill),
    .trigIn(trigIn), .readoutDone(readoutDone), .pwrAnalog(pwrAnalog),
    .pwrDac(pwrDac), .pwrDigital(pwrDigital), .acqEnable(acqEnable),
    .tsReset(tsReset), .trigOut(trigOut), .busy(busy),
    .passCount(passCount), .vetoCount(vetoCount)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // behavioural reference, evaluated between clock edges
  always @(negedge clk) begin
    if (modelOn && !done) begin
      automatic int  wake = WAKE;
      automatic bit  win, acq, pass;
      if (pulseMask[0] && ANA > wake) wake = ANA;
      if (pulseMask[1] && DAC > wake) wake = DAC;
      win  = (mPhase < ON);
      acq  = win && (mPhase >= wake);
      pass = trigIn && inSpill && acq && !mPending;
      chk("R1/R2 pwrAnalog",  pwrAnalog,  pulseMask[0] ? win : 1);
      chk("R1/R2 pwrDac",     pwrDac,     pulseMask[1] ? win : 1);
      chk("R3/R2 pwrDigital", pwrDigital, pulseMask[2] ? win : 1);
      chk("R4 acqEnable",     acqEnable,  acq);
      chk("R7 tsReset",       tsReset,    mPhase == 0);
      chk("R6 trigOut",       trigOut,    pass);
      chk("R5 busy",          busy,       !acq || mPending);
      chk("R8/R9 passCount",  passCount,  mPass);
      chk("R8/R9 vetoCount",  vetoCount,  mVeto);
      // advance to the state after the coming edge
      if (mPending && readoutDone) mPending = 1'b0;
      else if (pass)               mPending = 1'b1;
      if (pass && mPass < CMAX) mPass++;
      if (trigIn && !pass && mVeto < CMAX) mVeto++;
      mPhase = (mPhase == PERIOD - 1) ? 0 : mPhase + 1;
    end
  end

  task automatic drive(input int n, input logic [2:0] m, input logic sp,
                       input int tEvery, input int dEvery);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      pulseMask   = m;
      inSpill     = sp;
      trigIn      = (tEvery > 0) && ((i % tEvery) == 0);
      readoutDone = (dEvery > 0) && ((i % dEvery) == dEvery - 1);
    end
  endtask

  initial begin
    rstN = 1'b0; pulseMask = 3'b111; inSpill = 1'b0;
    trigIn = 1'b0; readoutDone = 1'b0;
    repeat (4) @(posedge clk);
    trigIn = 1'b1; inSpill = 1'b1;
    @(negedge clk);
    // R10: reset state seen at the ports
    chk("R10 passCount in reset", passCount, 0);
    chk("R10 vetoCount in reset", vetoCount, 0);
    chk("R10 tsReset in reset",   tsReset, 1);
    chk("R10 acqEnable in reset", acqEnable, 0);
    chk("R10 busy in reset",      busy, 1);
    chk("R10 trigOut in reset",   trigOut, 0);
    @(posedge clk); #1;
    trigIn = 1'b0;
    rstN = 1'b1;
    modelOn = 1'b1;
    // all lines pulsed, DAC sets the wake length
    drive(2 * PERIOD, 3'b111, 1'b1, 3, 5);
    // all lines always on, base wake applies
    drive(2 * PERIOD, 3'b000, 1'b1, 2, 4);
    // only DAC pulsed
    drive(2 * PERIOD, 3'b010, 1'b1, 3, 6);
    // analog only, shorter than the base wake; out of spill triggers
    drive(PERIOD, 3'b001, 1'b0, 1, 3);
    drive(PERIOD, 3'b101, 1'b1, 4, 9);
    // readout held off: pending spans window ends
    drive(PERIOD + 7, 3'b111, 1'b1, 1, 0);
    // dense triggers with quick readouts to saturate passCount
    drive(6 * PERIOD, 3'b011, 1'b1, 1, 2);
    chk("R9 passCount saturated", passCount, CMAX);
    chk("R9 vetoCount saturated", vetoCount, CMAX);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule